// File: doc/BRIEF.md
# DDR2 Write Data Burst Path

This block sits between a memory controller's command logic and the DDR I/O cells. It produces the write strobe and the data and byte-mask beats for DDR2 write bursts. When the command logic registers a WRITE, it pulses `wr_cmd` together with the burst length and the write latency. After that latency the block pulls one word per controller clock from a show-ahead data FIFO. Each word carries two beats, one for the rising strobe edge and one for the falling edge, and one mask bit for each byte of each beat.

The strobe is shown per half clock. `dqs_oe[0]` and `dqs_lvl[0]` describe the first half of a clock, and `dqs_oe[1]` and `dqs_lvl[1]` describe the second half. The block drives a one-clock low preamble before the first beat and a half-clock low postamble after the last beat. Bursts whose data clocks touch are merged into one continuous strobe, with no preamble or postamble between them. If the FIFO runs dry in the middle of a burst, the affected beats are masked off and an error pulse is raised. Outside bursts the data lanes are released and the FIFO is left alone.

Top module: `ddr2wr_burst_path`

## Requirements
- R1: A command sampled with effective latency W drives `dq_oe` high in the W-th clock after the sampling edge. It stays high for 2 clocks when `wr_bl8`=0 and for 4 clocks when `wr_bl8`=1.
- R2: In every data clock, `dqs_oe`=2'b11 and `dqs_lvl`=2'b01 (high first half, low second half). `dq_rise` carries `fifo_rdata[DQ_W-1:0]` and `dq_fall` carries `fifo_rdata[2*DQ_W-1:DQ_W]` of the popped word.
- R3: In the clock before the first data clock of a stream, `dqs_oe`=2'b11 and `dqs_lvl`=2'b00 (preamble).
- R4: In the clock after the last data clock of a stream, `dqs_oe`=2'b01 and `dqs_lvl`=2'b00 (half-clock postamble). Then the strobe is released (2'b00).
- R5: Mask bit 1 means the byte is not written. Bit i of `fifo_rmask` is forwarded as `dm_rise[i]` for i < DQ_W/8, and bit DQ_W/8+i is forwarded as `dm_fall[i]`.
- R6: Commands whose data clocks are adjacent or overlap form one unbroken run of data clocks, with no preamble or postamble inside it. A single idle clock between two runs shows `dqs_oe`=2'b11, `dqs_lvl`=2'b00.
- R7: Outside data clocks, `dq_oe`=0, the data lanes are zero and all mask bits are 1. Words waiting in the FIFO are not popped.
- R8: A data clock whose FIFO is empty at its loading edge pulses `underrun` for that clock. It outputs all-ones masks and zero data, and pops nothing.
- R9: `fifo_rd` is high only in the clock before a data clock and only while `fifo_empty` is low.
- R10: While `rst_n` is low, `dq_oe`, `dqs_oe`, `dqs_lvl`, `underrun` are 0 and all mask bits are 1.
- R11: A latency below 2 is treated as 2. A latency above WL_MAX is treated as WL_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd | input | 1 | One-clock pulse: WRITE command registered |
| wr_bl8 | input | 1 | Burst length select: 1 = eight beats, 0 = four beats |
| wr_lat | input | $clog2(WL_MAX+1) | Write latency in clocks |
| fifo_empty | input | 1 | Data FIFO has no word |
| fifo_rdata | input | 2*DQ_W | Head word: rising beat low half, falling beat high half |
| fifo_rmask | input | 2*DQ_W/8 | Head word byte masks, rising lanes low |
| fifo_rd | output | 1 | Pop the FIFO head at this edge |
| dq_rise | output | DQ_W | Beat for the rising strobe edge |
| dq_fall | output | DQ_W | Beat for the falling strobe edge |
| dm_rise | output | DQ_W/8 | Byte masks of the rising beat |
| dm_fall | output | DQ_W/8 | Byte masks of the falling beat |
| dq_oe | output | 1 | Data lanes driven |
| dqs_oe | output | 2 | Strobe driven, per half clock |
| dqs_lvl | output | 2 | Strobe level, per half clock |
| underrun | output | 1 | FIFO was empty for a data clock |

## Verification
The bench builds the block with DQ_W=16 (two byte lanes per beat) and WL_MAX=6, so the 3-bit latency input can reach 0, 1 and 7. That lets the clamping at both ends be hit. The short latency range makes commands from random traffic overlap often, which exercises merged streams, single-clock gaps and truncation by a following write. Two lanes are enough to show that mask bits steer each byte independently on both beats.

// File: rtl/ddr2wr_pkg.sv
package ddr2wr_pkg;

  localparam int LANE_W = 8;

  // per-half-clock strobe encodings: bit0 = first half, bit1 = second half
  localparam logic [1:0] HALF_OFF   = 2'b00;
  localparam logic [1:0] HALF_BOTH  = 2'b11;
  localparam logic [1:0] HALF_FIRST = 2'b01;
  localparam logic [1:0] LVL_LOW    = 2'b00;
  localparam logic [1:0] LVL_PULSE  = 2'b01;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_DATA = 2'd2,
    PH_POST = 2'd3
  } strobe_phase_e;

  function automatic int eff_latency(int lat, int lat_max);
    if (lat < 2) return 2;
    if (lat > lat_max) return lat_max;
    return lat;
  endfunction

  function automatic int burst_clocks(logic bl8);
    return bl8 ? 4 : 2;
  endfunction

endpackage

// File: rtl/ddr2wr_sched.sv
module ddr2wr_sched
  import ddr2wr_pkg::*;
#(
  parameter int WL_MAX = 8,
  parameter int LAT_W  = $clog2(WL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd,
  input  logic             bl8,
  input  logic [LAT_W-1:0] lat,
  output logic             data_now,
  output logic             data_next
);

  localparam int SLOTS = WL_MAX + 4;

  // slot_q[i] set: the clock after edge (now + 1 + i) is a data clock
  logic [SLOTS-1:0] slot_q;
  logic [SLOTS-1:0] add_v;
  int               first_slot;
  int               span;

  always_comb begin
    first_slot = eff_latency(int'(lat), WL_MAX) - 1;
    span       = burst_clocks(bl8);
    for (int i = 0; i < SLOTS; i++) begin
      add_v[i] = cmd && (i >= first_slot) && (i < first_slot + span);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= (slot_q >> 1) | add_v;
  end

  assign data_now  = slot_q[0];
  assign data_next = slot_q[1];

endmodule

// File: rtl/ddr2wr_strobe.sv
module ddr2wr_strobe
  import ddr2wr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_now,
  input  logic          data_next,
  output strobe_phase_e phase,
  output logic          dq_oe,
  output logic [1:0]    dqs_oe,
  output logic [1:0]    dqs_lvl
);

  logic data_prev;

  assign data_prev = dq_oe;

  always_comb begin
    if (data_now)       phase = PH_DATA;
    else if (data_next) phase = PH_PRE;
    else if (data_prev) phase = PH_POST;
    else                phase = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe   <= 1'b0;
      dqs_oe  <= HALF_OFF;
      dqs_lvl <= LVL_LOW;
    end else begin
      dq_oe <= (phase == PH_DATA);
      unique case (phase)
        PH_DATA: begin dqs_oe <= HALF_BOTH;  dqs_lvl <= LVL_PULSE; end
        PH_PRE:  begin dqs_oe <= HALF_BOTH;  dqs_lvl <= LVL_LOW;   end
        PH_POST: begin dqs_oe <= HALF_FIRST; dqs_lvl <= LVL_LOW;   end
        default: begin dqs_oe <= HALF_OFF;   dqs_lvl <= LVL_LOW;   end
      endcase
    end
  end

endmodule

// File: rtl/ddr2wr_beat.sv
module ddr2wr_beat
  import ddr2wr_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int LANES = DQ_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              fifo_empty,
  input  logic [2*DQ_W-1:0] fifo_rdata,
  input  logic [2*LANES-1:0] fifo_rmask,
  output logic              fifo_rd,
  output logic [DQ_W-1:0]   dq_rise,
  output logic [DQ_W-1:0]   dq_fall,
  output logic [LANES-1:0]  dm_rise,
  output logic [LANES-1:0]  dm_fall,
  output logic              underrun
);

  logic load;

  assign load    = take && !fifo_empty;
  assign fifo_rd = load;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq_rise[g*LANE_W +: LANE_W] <= '0;
        dq_fall[g*LANE_W +: LANE_W] <= '0;
        dm_rise[g]                  <= 1'b1;
        dm_fall[g]                  <= 1'b1;
      end else if (load) begin
        dq_rise[g*LANE_W +: LANE_W] <= fifo_rdata[g*LANE_W +: LANE_W];
        dq_fall[g*LANE_W +: LANE_W] <= fifo_rdata[DQ_W + g*LANE_W +: LANE_W];
        dm_rise[g]                  <= fifo_rmask[g];
        dm_fall[g]                  <= fifo_rmask[LANES + g];
      end else begin
        dq_rise[g*LANE_W +: LANE_W] <= '0;
        dq_fall[g*LANE_W +: LANE_W] <= '0;
        dm_rise[g]                  <= 1'b1;
        dm_fall[g]                  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underrun <= 1'b0;
    else        underrun <= take && fifo_empty;
  end

endmodule

// File: rtl/ddr2wr_burst_path.sv
module ddr2wr_burst_path
  import ddr2wr_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int WL_MAX = 8,
  localparam int LANES = DQ_W / LANE_W,
  localparam int LAT_W = $clog2(WL_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_cmd,
  input  logic               wr_bl8,
  input  logic [LAT_W-1:0]   wr_lat,
  input  logic               fifo_empty,
  input  logic [2*DQ_W-1:0]  fifo_rdata,
  input  logic [2*LANES-1:0] fifo_rmask,
  output logic               fifo_rd,
  output logic [DQ_W-1:0]    dq_rise,
  output logic [DQ_W-1:0]    dq_fall,
  output logic [LANES-1:0]   dm_rise,
  output logic [LANES-1:0]   dm_fall,
  output logic               dq_oe,
  output logic [1:0]         dqs_oe,
  output logic [1:0]         dqs_lvl,
  output logic               underrun
);

  // named internal events for the checker
  logic          data_now;
  logic          data_next;
  strobe_phase_e phase;

  ddr2wr_sched #(.WL_MAX(WL_MAX), .LAT_W(LAT_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (wr_cmd),
    .bl8       (wr_bl8),
    .lat       (wr_lat),
    .data_now  (data_now),
    .data_next (data_next)
  );

  ddr2wr_strobe u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_now  (data_now),
    .data_next (data_next),
    .phase     (phase),
    .dq_oe     (dq_oe),
    .dqs_oe    (dqs_oe),
    .dqs_lvl   (dqs_lvl)
  );

  ddr2wr_beat #(.DQ_W(DQ_W), .LANES(LANES)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (data_now),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .fifo_rmask (fifo_rmask),
    .fifo_rd    (fifo_rd),
    .dq_rise    (dq_rise),
    .dq_fall    (dq_fall),
    .dm_rise    (dm_rise),
    .dm_fall    (dm_fall),
    .underrun   (underrun)
  );

endmodule

// File: rtl/ddr2wr_burst_path_chk.sv
module ddr2wr_burst_path_chk #(
  parameter int DQ_W   = 16,
  parameter int LANES  = DQ_W / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_empty,
  input logic             fifo_rd,
  input logic             data_now,
  input logic             dq_oe,
  input logic [1:0]       dqs_oe,
  input logic [1:0]       dqs_lvl,
  input logic [DQ_W-1:0]  dq_rise,
  input logic [DQ_W-1:0]  dq_fall,
  input logic [LANES-1:0] dm_rise,
  input logic [LANES-1:0] dm_fall,
  input logic             underrun
);

  p_strobe_in_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe == 2'b11) && (dqs_lvl == 2'b01));

  p_preamble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(dqs_oe) == 2'b11) && ($past(dqs_lvl) == 2'b00));

  p_postamble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_lvl == 2'b00) && (dqs_oe != 2'b00));

  p_idle_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (&dm_rise) && (&dm_fall) && (dq_rise == '0) && (dq_fall == '0));

  p_underrun_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> dq_oe && (&dm_rise) && (&dm_fall));

  p_pop_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty && data_now);

  p_slot_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_now |=> dq_oe);

endmodule

bind ddr2wr_burst_path ddr2wr_burst_path_chk #(.DQ_W(DQ_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .data_now   (data_now),
  .dq_oe      (dq_oe),
  .dqs_oe     (dqs_oe),
  .dqs_lvl    (dqs_lvl),
  .dq_rise    (dq_rise),
  .dq_fall    (dq_fall),
  .dm_rise    (dm_rise),
  .dm_fall    (dm_fall),
  .underrun   (underrun)
);

// File: tb/ddr2wr_burst_path_tb.sv
module ddr2wr_burst_path_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DQ_W   = 16;
  localparam int WL_MAX = 6;
  localparam int LANES  = DQ_W / 8;
  localparam int LAT_W  = $clog2(WL_MAX + 1);
  localparam int WORD_W = 2 * DQ_W + 2 * LANES;
  localparam int RING   = 64;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_cmd = 1'b0;
  logic               wr_bl8 = 1'b0;
  logic [LAT_W-1:0]   wr_lat = '0;
  logic               fifo_empty = 1'b1;
  logic [2*DQ_W-1:0]  fifo_rdata = '0;
  logic [2*LANES-1:0] fifo_rmask = '0;
  logic               fifo_rd;
  logic [DQ_W-1:0]    dq_rise, dq_fall;
  logic [LANES-1:0]   dm_rise, dm_fall;
  logic               dq_oe, underrun;
  logic [1:0]         dqs_oe, dqs_lvl;

  ddr2wr_burst_path #(.DQ_W(DQ_W), .WL_MAX(WL_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_bl8(wr_bl8), .wr_lat(wr_lat),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rmask(fifo_rmask),
    .fifo_rd(fifo_rd), .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise),
    .dm_fall(dm_fall), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_lvl(dqs_lvl),
    .underrun(underrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  int          cyc     = 0;
  bit          done    = 1'b0;
  bit          busy [RING];
  logic [WORD_W-1:0] fq[$];
  logic [WORD_W-1:0] eq[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && fifo_rd && fq.size() > 0) fq.pop_front();
  end

  // keep the FIFO head on the pins after every pop
  always @(posedge clk) begin
    #1;
    fifo_empty = (fq.size() == 0);
    fifo_rdata = (fq.size() > 0) ? fq[0][2*DQ_W-1:0] : '0;
    fifo_rmask = (fq.size() > 0) ? fq[0][WORD_W-1:2*DQ_W] : '0;
  end

  function automatic int lat_rule(int l);
    return (l < 2) ? 2 : (l > WL_MAX) ? WL_MAX : l;
  endfunction

  function automatic int clocks_rule(bit b8);
    return b8 ? 4 : 2;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic push(logic [WORD_W-1:0] w);
    fq.push_back(w);
    eq.push_back(w);
    fifo_empty = 1'b0;
    fifo_rdata = fq[0][2*DQ_W-1:0];
    fifo_rmask = fq[0][WORD_W-1:2*DQ_W];
  endtask

  task automatic push_rand();
    push({$urandom, $urandom});
  endtask

  task automatic check_cycle();
    bit d, n, p;
    logic [1:0] e_oe, e_lvl;
    string stag;
    logic [WORD_W-1:0] w;
    d = busy[cyc % RING];
    n = busy[(cyc + 1) % RING];
    p = busy[(cyc + RING - 1) % RING];
    e_lvl = d ? 2'b01 : 2'b00;
    e_oe  = (d || n) ? 2'b11 : p ? 2'b01 : 2'b00;
    stag  = d ? "R2" : (n && p) ? "R6" : n ? "R3" : p ? "R4" : "R7";
    chk({dqs_oe, dqs_lvl} == {e_oe, e_lvl}, stag, "strobe oe/lvl",
        {dqs_oe, dqs_lvl}, {e_oe, e_lvl});
    chk(dq_oe == d, "R1", "dq_oe", dq_oe, d);
    chk(fifo_rd == (n && fq.size() > 0), "R9", "fifo_rd", fifo_rd, n && fq.size() > 0);
    if (d && eq.size() > 0) begin
      w = eq.pop_front();
      chk(!underrun, "R8", "underrun", underrun, 0);
      chk({dq_fall, dq_rise} == w[2*DQ_W-1:0], "R2", "beats",
          {dq_fall, dq_rise}, w[2*DQ_W-1:0]);
      chk({dm_fall, dm_rise} == w[WORD_W-1:2*DQ_W], "R5", "masks",
          {dm_fall, dm_rise}, w[WORD_W-1:2*DQ_W]);
    end else begin
      chk(underrun == d, "R8", "underrun", underrun, d);
      chk({dq_fall, dq_rise} == '0 && (&{dm_fall, dm_rise}), d ? "R8" : "R7",
          "lanes {dq,dm}", {dq_fall, dq_rise, dm_fall, dm_rise},
          {{(2*DQ_W){1'b0}}, {(2*LANES){1'b1}}});
    end
    busy[(cyc + RING - 2) % RING] = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) check_cycle();
    wr_cmd = 1'b0;
  endtask

  task automatic issue(bit b8, int l);
    int first;
    wr_cmd = 1'b1;
    wr_bl8 = b8;
    wr_lat = LAT_W'(l);
    first  = cyc + 1 + lat_rule(l);
    for (int i = 0; i < clocks_rule(b8); i++) busy[(first + i) % RING] = 1'b1;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  initial begin
    int start;
    void'($urandom(32'h5eed_2417));
    for (int i = 0; i < RING; i++) busy[i] = 1'b0;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!dq_oe && dqs_oe == 2'b00 && dqs_lvl == 2'b00 && !underrun, "R10", "reset strobe",
        {dq_oe, dqs_oe, dqs_lvl, underrun}, 0);
    chk(&{dm_fall, dm_rise}, "R10", "reset masks", {dm_fall, dm_rise}, {(2*LANES){1'b1}});
    rst_n = 1'b1;
    idle(2);

    // R1, R3, R4: single short burst at minimum latency
    push_rand(); push_rand();
    issue(1'b0, 2); idle(8);

    // R1, R5: long burst at maximum latency with fixed masks
    push({4'b1010, 32'hCAFE_F00D}); push({4'b0101, 32'h1234_5678});
    push({4'b1111, 32'hDEAD_BEEF}); push({4'b0000, 32'h0BAD_F00D});
    issue(1'b1, WL_MAX); idle(WL_MAX + 8);

    // R6: back-to-back short bursts merge into one run
    repeat (4) push_rand();
    issue(1'b0, 3); tick(); tick(); issue(1'b0, 3); idle(10);

    // R6: one idle clock between two bursts
    repeat (4) push_rand();
    issue(1'b0, 3); tick(); tick(); tick(); issue(1'b0, 3); idle(10);

    // R8: burst with empty FIFO, then a long burst short of data
    issue(1'b0, 2); idle(6);
    push_rand();
    issue(1'b1, 4); idle(10);

    // R7: waiting words are not taken without a command
    repeat (3) push_rand();
    idle(6);
    chk(fq.size() == 3, "R7", "fifo depth while idle", fq.size(), 3);
    issue(1'b1, 2); idle(8);

    // R11: latency below 2 and above WL_MAX are clamped
    push_rand(); push_rand();
    issue(1'b0, 0); start = cyc + 1;
    while (cyc < start + 1) tick();
    chk(!dq_oe, "R11", "no data one clock after low-latency cmd", dq_oe, 0);
    tick();
    chk(dq_oe, "R11", "data two clocks after low-latency cmd", dq_oe, 1);
    idle(6);
    push_rand(); push_rand();
    issue(1'b0, WL_MAX + 1); start = cyc + 1;
    while (cyc < start + WL_MAX) tick();
    chk(dq_oe, "R11", "data at clamped high latency", dq_oe, 1);
    idle(6);

    // random traffic mixed across all rules
    for (int c = 0; c < 4000; c++) begin
      if (fq.size() < 12 && ($urandom % 4) != 0) push_rand();
      if (($urandom % 5) == 0) issue(1'(($urandom % 2)), int'($urandom % (WL_MAX + 2)));
      tick();
    end
    idle(WL_MAX + 8);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule